// File: doc/BRIEF.md
# Multichannel Clock Select-Divide-Gate Bank

This block drives sixteen output channels from four parent clock sources. Each channel picks one parent, divides it by a power of two (1, 2, 4 or 8), and can be switched off. All sixteen channels are configured through three shared 32-bit registers on a simple memory-mapped bus. The registers hold a disable mask, a packed source-select word and a packed divider-exponent word.

The model is fully synchronous to one system clock. Each parent is a one-cycle enable strobe, and each channel produces a one-cycle enable strobe that downstream logic uses as a clock enable. Inside every channel the stages run in a fixed order: source selection, then a per-channel division counter, then the gate. A channel is reconfigured by writing its field. The counter restarts whenever the channel's select or divider field changes. While the gate holds the channel off, the counter is frozen, and it resumes from where it stopped.

Top module: `clk_chan_bank`

## Requirements
- R1: After reset all three registers read zero, `ch_stb` is zero, and every channel passes each strobe of parent 0 undivided.
- R2: Byte offset 0x0 is the gate register, 0x4 the select register and 0x8 the divider register. Each reads back the last value written. A read at any other offset returns zero.
- R3: A write to any offset other than 0x0, 0x4 or 0x8 leaves all three registers and all channel outputs unchanged.
- R4: Gate bit i set to 1 holds channel i's output low. Channels whose gate bit is 0 keep running.
- R5: Select bits [2i+1:2i] give the parent index (0 to 3) that channel i counts.
- R6: Divider bits [2i+1:2i] hold an exponent k. Channel i emits one strobe for every 2^k strobes of its parent. The output strobe appears in the cycle after the parent strobe that completes the count.
- R7: When channel i's select or divider field changes, its counter restarts from zero, so the next output comes after a full new period.
- R8: While a channel is gated, its counter holds its value. After the gate is released, counting resumes from that held value.
- R9: A write is accepted on the clock edge where `bus_sel` and `bus_we` are high. The written value governs the channels from the next cycle on.
- R10: If a channel's field changes while the channel is gated, the counter restart takes priority over the freeze.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write (1) or read (0) |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while `bus_sel` is high |
| src_stb | input | 4 | Parent enable strobes |
| ch_stb | output | 16 | Channel enable strobes |

## Verification
Two functions can act on a channel's counter in the same cycle: the restart caused by a field change and the freeze caused by the gate. The bench provokes this clash in three steps. It advances a divide-by-2 channel by one strobe, gates it, and then changes its divider to divide-by-8 while it is still gated. After the gate is released, the channel must stay silent through seven parent strobes and fire on the eighth. If the freeze had won, the channel would fire one strobe early. A second directed case rewrites the divider of an ungated channel in mid-count to show that the restart alone discards the partial count.

// File: rtl/clkbank_pkg.sv
// Package: shared constants for the channel bank.
// Assumes byte addressing with 32-bit registers on word boundaries.
package clkbank_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] OFS_GATE = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_SEL  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 4'h8;
endpackage

// File: rtl/clkbank_regs.sv
// Register file: holds the gate, select and divider words.
// Assumes single-cycle accesses. Writes land on the accepting edge.
// Reads are combinational and return zero for undecoded offsets.
module clkbank_regs
    import clkbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] gate_r,
    output logic [DATA_W-1:0] sel_r,
    output logic [DATA_W-1:0] div_r
);
    logic hit_gate, hit_sel, hit_div, wr;

    // Decode the offset.
    always_comb begin
        hit_gate = (bus_addr == OFS_GATE);
        hit_sel  = (bus_addr == OFS_SEL);
        hit_div  = (bus_addr == OFS_DIV);
        wr       = bus_sel && bus_we;
    end

    // Update the stored words on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_r <= '0;
            sel_r  <= '0;
            div_r  <= '0;
        end else if (wr) begin
            if (hit_gate) gate_r <= bus_wdata;
            if (hit_sel)  sel_r  <= bus_wdata;
            if (hit_div)  div_r  <= bus_wdata;
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (hit_gate)     bus_rdata = gate_r;
            else if (hit_sel) bus_rdata = sel_r;
            else if (hit_div) bus_rdata = div_r;
        end
    end

    AST_BAD_OFS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit_gate && !hit_sel && !hit_div) |=>
        ($stable(gate_r) && $stable(sel_r) && $stable(div_r))); // R3

    AST_GATE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_gate) |=> (gate_r == $past(bus_wdata))); // R9
endmodule

// File: rtl/clkbank_src_sel.sv
// Source selector: forwards the parent strobe picked by the select field.
// Assumes NUM_SRC is a power of two, so every field value is a valid index.
module clkbank_src_sel #(
    parameter int NUM_SRC = 4,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] src_stb,
    input  logic [SEL_W-1:0]   sel_fld,
    output logic               src_hit
);
    // Pick one parent strobe.
    always_comb src_hit = src_stb[sel_fld];
endmodule

// File: rtl/clkbank_chan.sv
// Channel core: power-of-two pulse divider followed by a gate.
// Assumes the select and divider fields come from registers.
// A field change clears the counter, even while the channel is gated.
module clkbank_chan #(
    parameter int SEL_W = 2,
    parameter int DIV_W = 2,
    localparam int CNT_W = (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_hit,
    input  logic [SEL_W-1:0] sel_fld,
    input  logic [DIV_W-1:0] div_fld,
    input  logic             gate_off,
    output logic             out_stb
);
    logic [SEL_W-1:0] sel_seen;
    logic [DIV_W-1:0] div_seen;
    logic [CNT_W-1:0] cnt, lim;
    logic             cfg_chg;

    // Detect a configuration change and derive the terminal count.
    always_comb begin
        cfg_chg = (sel_fld != sel_seen) || (div_fld != div_seen);
        lim     = CNT_W'((32'd1 << div_fld) - 32'd1);
    end

    // Count parent strobes: restart wins over the gate's freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_seen <= '0;
            div_seen <= '0;
            cnt      <= '0;
            out_stb  <= 1'b0;
        end else begin
            sel_seen <= sel_fld;
            div_seen <= div_fld;
            out_stb  <= 1'b0;
            if (cfg_chg) begin
                cnt <= '0;
            end else if (!gate_off && src_hit) begin
                if (cnt == lim) begin
                    cnt     <= '0;
                    out_stb <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off |=> !out_stb); // R4

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_chg |-> (cnt <= lim)); // R6

    AST_OUT_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |-> $past(src_hit)); // R6

    AST_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (cnt == '0)); // R7

    AST_GATE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_off && !cfg_chg) |=> $stable(cnt)); // R8
endmodule

// File: rtl/clk_chan_bank.sv
// Top: register file plus one selector and one divider/gate per channel.
// Assumes NUM_CH*SEL_W and NUM_CH*DIV_W fit in one register word.
module clk_chan_bank
    import clkbank_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int NUM_SRC = 4,
    parameter int DIV_W   = 2,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] src_stb,
    output logic [NUM_CH-1:0]  ch_stb
);
    logic [DATA_W-1:0] gate_r, sel_r, div_r;

    clkbank_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gate_r(gate_r), .sel_r(sel_r), .div_r(div_r)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;

        clkbank_src_sel #(.NUM_SRC(NUM_SRC)) u_sel (
            .src_stb(src_stb),
            .sel_fld(sel_r[SEL_W*i +: SEL_W]),
            .src_hit(hit)
        );

        clkbank_chan #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .src_hit(hit),
            .sel_fld(sel_r[SEL_W*i +: SEL_W]),
            .div_fld(div_r[DIV_W*i +: DIV_W]),
            .gate_off(gate_r[i]),
            .out_stb(ch_stb[i])
        );
    end
endmodule

// File: tb/clk_chan_bank_test.sv
module clk_chan_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [3:0]  src_stb = '0;
    logic [15:0] ch_stb;
    int errors = 0, checks = 0;

    clk_chan_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_stb(src_stb), .ch_stb(ch_stb)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic idle;
        @(negedge clk);
    endtask

    // One parent strobe cycle. Returns ch_stb in the following cycle.
    task automatic strobe(input logic [3:0] m, output logic [15:0] o);
        src_stb = m;
        @(negedge clk);
        src_stb = '0;
        o = ch_stb;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic [15:0] o;
        rd(4'h0, d); chk("R1 gate reset", d, 0);
        rd(4'h4, d); chk("R1 sel reset", d, 0);
        rd(4'h8, d); chk("R1 div reset", d, 0);
        chk("R1 outputs idle", {16'h0, ch_stb}, 0);
        strobe(4'b0001, o); chk("R1 parent0 pass", {16'h0, o}, 32'hFFFF);
        idle; chk("R6 one-cycle strobe", {16'h0, ch_stb}, 0);
        strobe(4'b1110, o); chk("R1 other parents ignored", {16'h0, o}, 0);
    endtask

    task automatic t_regs;
        logic [31:0] d; logic [15:0] o;
        wr(4'h4, 32'hA5A5_1234); rd(4'h4, d); chk("R2 sel readback", d, 32'hA5A5_1234);
        wr(4'h8, 32'h0F0F_F0F0); rd(4'h8, d); chk("R2 div readback", d, 32'h0F0F_F0F0);
        wr(4'h0, 32'h0000_8001); rd(4'h0, d); chk("R2 gate readback", d, 32'h0000_8001);
        rd(4'hC, d); chk("R2 undecoded read", d, 0);
        rd(4'h2, d); chk("R2 unaligned read", d, 0);
        wr(4'h0, 0); wr(4'h4, 0); wr(4'h8, 0);
        wr(4'hC, 32'hFFFF_FFFF); wr(4'h1, 32'hFFFF_FFFF);
        rd(4'h0, d); chk("R3 gate untouched", d, 0);
        rd(4'h4, d); chk("R3 sel untouched", d, 0);
        rd(4'h8, d); chk("R3 div untouched", d, 0);
        strobe(4'b0001, o); chk("R3 outputs unchanged", {16'h0, o}, 32'hFFFF);
    endtask

    task automatic t_select;
        logic [15:0] o, e;
        wr(4'h4, 32'hE4E4_E4E4); idle;
        for (int k = 0; k < 4; k++) begin
            e = 16'h1111 << k;
            strobe(4'b0001 << k, o); chk("R5 source select", {16'h0, o}, {16'h0, e});
        end
        wr(4'h4, 0); idle;
    endtask

    task automatic t_divide;
        logic [15:0] o, e;
        wr(4'h8, 32'hE4E4_E4E4); idle;
        for (int j = 1; j <= 8; j++) begin
            e = '0;
            for (int i = 0; i < 16; i++) e[i] = ((j % (1 << (i % 4))) == 0);
            strobe(4'b0001, o); chk("R6 divide ratios", {16'h0, o}, {16'h0, e});
        end
    endtask

    task automatic t_restart;
        logic [15:0] o;
        wr(4'h8, 32'h2); idle;
        strobe(1, o); strobe(1, o);
        wr(4'h8, 32'h3); idle;
        for (int j = 1; j <= 7; j++) begin
            strobe(1, o); chk("R7 restart after change", {31'h0, o[0]}, 0);
        end
        strobe(1, o); chk("R7 full new period", {31'h0, o[0]}, 1);
    endtask

    task automatic t_gate;
        logic [15:0] o;
        wr(4'h8, 32'h1); idle;
        strobe(1, o); chk("R6 half count", {31'h0, o[0]}, 0);
        wr(4'h0, 32'h1);
        strobe(1, o); chk("R9 gate next cycle", {16'h0, o}, 32'hFFFE);
        strobe(1, o); strobe(1, o);
        chk("R4 gated only ch0", {16'h0, o}, 32'hFFFE);
        wr(4'h0, 32'h0);
        strobe(1, o); chk("R8 resume from frozen", {31'h0, o[0]}, 1);
    endtask

    task automatic t_gated_change;
        logic [15:0] o;
        wr(4'h8, 32'h1); idle;
        strobe(1, o);
        wr(4'h0, 32'h1);
        wr(4'h8, 32'h3); idle;
        wr(4'h0, 32'h0);
        for (int j = 1; j <= 7; j++) begin
            strobe(1, o); chk("R10 restart beats freeze", {31'h0, o[0]}, 0);
        end
        strobe(1, o); chk("R10 eighth strobe fires", {31'h0, o[0]}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_select;
        t_divide;
        t_restart;
        wr(4'h8, 0); idle;
        t_gate;
        wr(4'h8, 0); idle;
        t_gated_change;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule